// File: doc/BRIEF.md
# Dual-Rail Fault and Power-Good Supervisor

This block watches two regulator channels, a main supply rail and a termination rail that tracks it, through digitized comparator flags. For each channel it reports power-good. It latches overvoltage and undervoltage faults, and it drives the two protective responses. An overvoltage fault forces the low-side switch on. An undervoltage fault floats both drive outputs.

Every comparator condition must hold for a programmable number of system clock cycles before it takes effect. Once a fault is qualified, the channel stays off until a defined re-arm event occurs on that channel. A re-arm event is a falling level followed by a rising level on one of the channel's own control inputs. Those inputs are synchronized inside the block.

A fault on the main rail can also shut the termination rail down. This happens only when a configuration input says the termination reference is derived from the main rail. A fault on the termination rail never reaches the main rail.

Top module: `dual_rail_supervisor`

## Requirements
- R1: While reset is asserted and immediately after its release, every pgood, lo_force and hiz output is 0.
- R2: A change of any comparator condition (overvoltage, undervoltage or power-good condition) takes effect only after the new level has been sampled on FILT_CYCLES consecutive clock edges. A shorter pulse has no effect on any output.
- R3: A running channel raises pgood only when its soft-start-done input and reached-90% input are both 1 and its out-of-window input is 0, after filtering.
- R4: pgood of a channel falls after its out-of-window input has been 1 for the filter time, and rises again once that input has been 0 for the filter time.
- R5: One cycle after a filtered overvoltage, a running channel latches into the overvoltage state: lo_force=1, hiz=0, pgood=0. It holds that state until a re-arm event, even after the overvoltage input clears.
- R6: One cycle after a filtered undervoltage, a running channel latches into the undervoltage state: hiz=1, lo_force=0, pgood=0. It holds that state until a re-arm event.
- R7: An undervoltage input is ignored while that channel's soft-start-done input is 0.
- R8: When overvoltage and undervoltage qualify on the same edge, the channel takes the overvoltage state.
- R9: No termination-rail fault changes any main-rail output.
- R10: When ref_from_main=1, a latched main-rail fault latches the termination rail one cycle later into the off state (hiz=1, lo_force=0, pgood=0). When ref_from_main=0, main-rail faults do not affect the termination rail.
- R11: The main channel latch clears three clock edges after the rising level reaches main_supply_ok or main_en, and only if that input was previously seen low after reset or after its last clear.
- R12: The termination channel latch clears by the same rule, using term_supply_ok or term_ref_ok. Main-rail re-arm events do not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_from_main | input | 1 | 1: termination reference is derived from the main rail |
| main_ov | input | 1 | Main rail overvoltage comparator flag |
| main_uv | input | 1 | Main rail undervoltage comparator flag |
| main_win_bad | input | 1 | Main rail outside its good window |
| main_at90 | input | 1 | Main rail has reached 90% of target |
| main_ss_done | input | 1 | Main rail soft start finished |
| main_en | input | 1 | Main rail enable, re-arm source |
| main_supply_ok | input | 1 | Main controller supply good, re-arm source |
| term_ov | input | 1 | Termination rail overvoltage comparator flag |
| term_uv | input | 1 | Termination rail undervoltage comparator flag |
| term_win_bad | input | 1 | Termination rail outside its good window |
| term_at90 | input | 1 | Termination rail has reached 90% of target |
| term_ss_done | input | 1 | Termination rail soft start finished |
| term_ref_ok | input | 1 | Termination reference present, re-arm source |
| term_supply_ok | input | 1 | Termination controller supply good, re-arm source |
| main_pgood | output | 1 | Main rail power good |
| main_lo_force | output | 1 | Main rail low-side switch forced on |
| main_hiz | output | 1 | Main rail drivers tri-stated |
| term_pgood | output | 1 | Termination rail power good |
| term_lo_force | output | 1 | Termination rail low-side switch forced on |
| term_hiz | output | 1 | Termination rail drivers tri-stated |

## Verification
The bench builds the block with FILT_CYCLES=4 instead of the 500-cycle default. With that value, filter expiry, glitch rejection just below the threshold, and the one-cycle latch step all fall within a few dozen cycles. This makes room to cover several full fault-and-re-arm sequences on both rails, with both settings of ref_from_main, inside a short run. A behavioural model in the bench advances in step with the design and is compared with all six outputs on every cycle, so the exact edge of each filter expiry and each latch clear is checked.

// File: rtl/rail_sup_pkg.sv
`timescale 1ns/1ps
package rail_sup_pkg;

    typedef enum logic [1:0] {
        CH_RUN = 2'd0,
        CH_OV  = 2'd1,
        CH_UV  = 2'd2,
        CH_OFF = 2'd3
    } ch_state_e;

    typedef struct packed {
        ch_state_e state;
    } chan_reg_t;

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
        logic armed;
    } rearm_reg_t;

    localparam int FLAG_OV   = 0;
    localparam int FLAG_UV   = 1;
    localparam int FLAG_GOOD = 2;
    localparam int FLAGS_PER_CH = 3;

endpackage

// File: rtl/glitch_filter.sv
`timescale 1ns/1ps
module glitch_filter #(
    parameter int FILT_CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_i,
    output logic out_o
);
    localparam int CW = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;

    typedef struct packed {
        logic          out;
        logic [CW-1:0] cnt;
    } filt_reg_t;

    filt_reg_t q, d;

    always_comb begin
        d = q;
        if (in_i != q.out) begin
            if (q.cnt == CW'(FILT_CYCLES - 1)) begin
                d.out = in_i;
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + CW'(1);
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_o = q.out;

    // output only moves to a level the input held on the previous edge
    assert_follow_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.out != $past(q.out)) |-> (q.out == $past(in_i)));

endmodule

// File: rtl/rearm_detect.sv
`timescale 1ns/1ps
module rearm_detect
    import rail_sup_pkg::*;
#(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    output logic            clr_o
);
    logic [NSRC-1:0] hit;

    for (genvar k = 0; k < NSRC; k++) begin : g_src
        rearm_reg_t q, d;
        logic rise, fall;

        always_comb begin
            rise = q.s2 && !q.s3;
            fall = q.s3 && !q.s2;
            d    = q;
            d.s1 = src_i[k];
            d.s2 = q.s1;
            d.s3 = q.s2;
            if (fall)      d.armed = 1'b1;
            else if (rise) d.armed = 1'b0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d;
        end

        assign hit[k] = rise && q.armed;

        // a clear needs a fresh low phase, so it never repeats on the next edge (R11, R12)
        assert_single_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
            hit[k] |=> !hit[k]);
    end

    assign clr_o = |hit;

endmodule

// File: rtl/rail_channel.sv
`timescale 1ns/1ps
module rail_channel
    import rail_sup_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ov_f_i,
    input  logic uv_f_i,
    input  logic good_f_i,
    input  logic kill_i,
    input  logic clr_i,
    output logic pgood_o,
    output logic lo_force_o,
    output logic hiz_o,
    output logic faulted_o
);
    chan_reg_t q, d;

    always_comb begin
        d = q;
        if (clr_i) begin
            d.state = CH_RUN;
        end else if (q.state == CH_RUN) begin
            if (ov_f_i)      d.state = CH_OV;
            else if (uv_f_i) d.state = CH_UV;
            else if (kill_i) d.state = CH_OFF;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: CH_RUN};
        else        q <= d;
    end

    assign pgood_o    = (q.state == CH_RUN) && good_f_i;
    assign lo_force_o = (q.state == CH_OV);
    assign hiz_o      = (q.state == CH_UV) || (q.state == CH_OFF);
    assign faulted_o  = (q.state != CH_RUN);

    assert_ov_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_force_o) |-> $past(ov_f_i));

    assert_ov_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_force_o && !clr_i) |=> lo_force_o);

    assert_hiz_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hiz_o) |-> $past(uv_f_i || kill_i));

    assert_ov_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!faulted_o && ov_f_i && uv_f_i && !clr_i) |=> lo_force_o);

endmodule

// File: rtl/dual_rail_supervisor.sv
`timescale 1ns/1ps
module dual_rail_supervisor
    import rail_sup_pkg::*;
#(
    parameter int FILT_CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_from_main,
    input  logic main_ov,
    input  logic main_uv,
    input  logic main_win_bad,
    input  logic main_at90,
    input  logic main_ss_done,
    input  logic main_en,
    input  logic main_supply_ok,
    input  logic term_ov,
    input  logic term_uv,
    input  logic term_win_bad,
    input  logic term_at90,
    input  logic term_ss_done,
    input  logic term_ref_ok,
    input  logic term_supply_ok,
    output logic main_pgood,
    output logic main_lo_force,
    output logic main_hiz,
    output logic term_pgood,
    output logic term_lo_force,
    output logic term_hiz
);
    localparam int NFLAG = 2 * FLAGS_PER_CH;
    localparam int TOFS  = FLAGS_PER_CH;

    logic [NFLAG-1:0] raw, filt;
    logic main_clr, term_clr, main_fault, term_fault, term_kill;

    always_comb begin
        raw[FLAG_OV]          = main_ov;
        raw[FLAG_UV]          = main_uv && main_ss_done;
        raw[FLAG_GOOD]        = main_ss_done && main_at90 && !main_win_bad;
        raw[TOFS + FLAG_OV]   = term_ov;
        raw[TOFS + FLAG_UV]   = term_uv && term_ss_done;
        raw[TOFS + FLAG_GOOD] = term_ss_done && term_at90 && !term_win_bad;
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_filt
        glitch_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .in_i  (raw[i]),
            .out_o (filt[i])
        );
    end

    rearm_detect #(.NSRC(2)) u_main_rearm (
        .clk   (clk),
        .rst_n (rst_n),
        .src_i ({main_en, main_supply_ok}),
        .clr_o (main_clr)
    );

    rearm_detect #(.NSRC(2)) u_term_rearm (
        .clk   (clk),
        .rst_n (rst_n),
        .src_i ({term_ref_ok, term_supply_ok}),
        .clr_o (term_clr)
    );

    rail_channel u_main (
        .clk        (clk),
        .rst_n      (rst_n),
        .ov_f_i     (filt[FLAG_OV]),
        .uv_f_i     (filt[FLAG_UV]),
        .good_f_i   (filt[FLAG_GOOD]),
        .kill_i     (1'b0),
        .clr_i      (main_clr),
        .pgood_o    (main_pgood),
        .lo_force_o (main_lo_force),
        .hiz_o      (main_hiz),
        .faulted_o  (main_fault)
    );

    assign term_kill = ref_from_main && main_fault;

    rail_channel u_term (
        .clk        (clk),
        .rst_n      (rst_n),
        .ov_f_i     (filt[TOFS + FLAG_OV]),
        .uv_f_i     (filt[TOFS + FLAG_UV]),
        .good_f_i   (filt[TOFS + FLAG_GOOD]),
        .kill_i     (term_kill),
        .clr_i      (term_clr),
        .pgood_o    (term_pgood),
        .lo_force_o (term_lo_force),
        .hiz_o      (term_hiz),
        .faulted_o  (term_fault)
    );

    // termination off-state without its own undervoltage must come from the main rail
    assert_cross_kill_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(term_hiz) && !$past(filt[TOFS + FLAG_UV])) |-> $past(ref_from_main && main_fault));

    // termination state never feeds the main channel
    assert_main_isolated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(main_fault)) |-> $past(filt[FLAG_OV] || filt[FLAG_UV]));

    assert_term_fault_seen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(term_fault) |-> $past(filt[TOFS + FLAG_OV] || filt[TOFS + FLAG_UV] || term_kill));

endmodule

// File: tb/sim_dual_rail_supervisor.sv
`timescale 1ns/1ps
module sim_dual_rail_supervisor;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_from_main = 0;
    logic main_ov = 0, main_uv = 0, main_win_bad = 0, main_at90 = 0, main_ss_done = 0;
    logic main_en = 1, main_supply_ok = 1;
    logic term_ov = 0, term_uv = 0, term_win_bad = 0, term_at90 = 0, term_ss_done = 0;
    logic term_ref_ok = 1, term_supply_ok = 1;
    logic main_pgood, main_lo_force, main_hiz, term_pgood, term_lo_force, term_hiz;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dual_rail_supervisor #(.FILT_CYCLES(N)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_from_main(ref_from_main),
        .main_ov(main_ov), .main_uv(main_uv), .main_win_bad(main_win_bad),
        .main_at90(main_at90), .main_ss_done(main_ss_done), .main_en(main_en),
        .main_supply_ok(main_supply_ok),
        .term_ov(term_ov), .term_uv(term_uv), .term_win_bad(term_win_bad),
        .term_at90(term_at90), .term_ss_done(term_ss_done), .term_ref_ok(term_ref_ok),
        .term_supply_ok(term_supply_ok),
        .main_pgood(main_pgood), .main_lo_force(main_lo_force), .main_hiz(main_hiz),
        .term_pgood(term_pgood), .term_lo_force(term_lo_force), .term_hiz(term_hiz)
    );

    // ---------------- behavioural reference ----------------
    // channel modes: 0 running, 1 overvoltage, 2 undervoltage, 3 shut by main
    int m_fo[6];
    int m_fc[6];
    int m_hist[4][3];
    int m_arm[4];
    int m_mst = 0;
    int m_tst = 0;

    always @(posedge clk or negedge rst_n) begin
        int r[6];
        int src[4];
        int rise[4];
        int mclr, tclr, kill, nm, nt;
        if (!rst_n) begin
            for (int i = 0; i < 6; i++) begin m_fo[i] = 0; m_fc[i] = 0; end
            for (int k = 0; k < 4; k++) begin
                m_arm[k] = 0;
                for (int j = 0; j < 3; j++) m_hist[k][j] = 0;
            end
            m_mst = 0; m_tst = 0;
        end else begin
            r[0] = main_ov; r[1] = main_uv & main_ss_done;
            r[2] = main_ss_done & main_at90 & ~main_win_bad;
            r[3] = term_ov; r[4] = term_uv & term_ss_done;
            r[5] = term_ss_done & term_at90 & ~term_win_bad;
            src[0] = main_supply_ok; src[1] = main_en;
            src[2] = term_supply_ok; src[3] = term_ref_ok;
            for (int k = 0; k < 4; k++) rise[k] = (m_hist[k][1] == 1 && m_hist[k][2] == 0) ? 1 : 0;
            mclr = (rise[0] && m_arm[0]) || (rise[1] && m_arm[1]);
            tclr = (rise[2] && m_arm[2]) || (rise[3] && m_arm[3]);
            kill = ref_from_main && (m_mst != 0);
            nm = m_mst;
            if (mclr) nm = 0;
            else if (m_mst == 0) nm = m_fo[0] ? 1 : (m_fo[1] ? 2 : 0);
            nt = m_tst;
            if (tclr) nt = 0;
            else if (m_tst == 0) nt = m_fo[3] ? 1 : (m_fo[4] ? 2 : (kill ? 3 : 0));
            m_mst = nm; m_tst = nt;
            for (int k = 0; k < 4; k++) begin
                if (m_hist[k][2] == 1 && m_hist[k][1] == 0) m_arm[k] = 1;
                else if (rise[k]) m_arm[k] = 0;
                m_hist[k][2] = m_hist[k][1];
                m_hist[k][1] = m_hist[k][0];
                m_hist[k][0] = src[k];
            end
            for (int i = 0; i < 6; i++) begin
                if (r[i] != m_fo[i]) begin
                    if (m_fc[i] == N - 1) begin m_fo[i] = r[i]; m_fc[i] = 0; end
                    else m_fc[i]++;
                end else m_fc[i] = 0;
            end
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3/R4 main_pgood model", main_pgood, logic'(m_mst == 0 && m_fo[2] == 1));
            check("R5 main_lo_force model", main_lo_force, logic'(m_mst == 1));
            check("R6 main_hiz model", main_hiz, logic'(m_mst == 2 || m_mst == 3));
            check("R3/R4 term_pgood model", term_pgood, logic'(m_tst == 0 && m_fo[5] == 1));
            check("R5 term_lo_force model", term_lo_force, logic'(m_tst == 1));
            check("R10 term_hiz model", term_hiz, logic'(m_tst == 2 || m_tst == 3));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #2000000;
        tests++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        tick(3);
        check("R1 reset main_pgood", main_pgood, 1'b0);
        check("R1 reset main_lo_force", main_lo_force, 1'b0);
        check("R1 reset term_hiz", term_hiz, 1'b0);
        rst_n = 1;
        tick(1);
        check("R1 released main_hiz", main_hiz, 1'b0);
        check("R1 released term_lo_force", term_lo_force, 1'b0);

        // R7: undervoltage during soft start is ignored
        main_uv = 1; main_at90 = 1; term_at90 = 1;
        tick(12);
        check("R7 main_hiz during soft start", main_hiz, 1'b0);
        check("R3 pgood held low without ss_done", main_pgood, 1'b0);
        main_uv = 0;

        // R3: power good after soft start
        main_ss_done = 1; term_ss_done = 1;
        tick(2);
        check("R2 pgood not yet qualified", main_pgood, 1'b0);
        tick(6);
        check("R3 main_pgood", main_pgood, 1'b1);
        check("R3 term_pgood", term_pgood, 1'b1);

        // R2 / R4: window glitch vs persistent excursion
        main_win_bad = 1; tick(N - 1); main_win_bad = 0;
        tick(6);
        check("R2 short window glitch ignored", main_pgood, 1'b1);
        main_ov = 1; tick(N - 1); main_ov = 0;
        tick(6);
        check("R2 short overvoltage ignored", main_lo_force, 1'b0);
        main_win_bad = 1; tick(8);
        check("R4 pgood drops", main_pgood, 1'b0);
        main_win_bad = 0; tick(8);
        check("R4 pgood returns", main_pgood, 1'b1);

        // R5 / R9: termination overvoltage
        term_ov = 1; tick(8);
        check("R5 term_lo_force", term_lo_force, 1'b1);
        check("R5 term_hiz low", term_hiz, 1'b0);
        check("R5 term_pgood low", term_pgood, 1'b0);
        check("R9 main_pgood unaffected", main_pgood, 1'b1);
        check("R9 main_lo_force unaffected", main_lo_force, 1'b0);
        term_ov = 0; tick(20);
        check("R5 latch holds", term_lo_force, 1'b1);
        main_en = 0; tick(6); main_en = 1; tick(6);
        check("R12 main re-arm leaves term latched", term_lo_force, 1'b1);
        term_ref_ok = 0; tick(6); term_ref_ok = 1; tick(6);
        check("R12 term cleared by ref toggle", term_lo_force, 1'b0);
        check("R12 term pgood back", term_pgood, 1'b1);

        // R6 / R10: main undervoltage with derived reference
        ref_from_main = 1;
        main_uv = 1; tick(8);
        check("R6 main_hiz", main_hiz, 1'b1);
        check("R6 main_lo_force low", main_lo_force, 1'b0);
        check("R10 term shut by main", term_hiz, 1'b1);
        main_uv = 0; tick(8);
        main_en = 0; tick(6); main_en = 1; tick(6);
        check("R11 main cleared by enable toggle", main_hiz, 1'b0);
        check("R11 main pgood back", main_pgood, 1'b1);
        check("R12 term stays off until own re-arm", term_hiz, 1'b1);
        term_supply_ok = 0; tick(6); term_supply_ok = 1; tick(6);
        check("R12 term cleared by supply toggle", term_hiz, 1'b0);

        // R10: independent reference, main overvoltage
        ref_from_main = 0;
        main_ov = 1; tick(8);
        check("R5 main_lo_force", main_lo_force, 1'b1);
        check("R10 term unaffected", term_hiz, 1'b0);
        check("R10 term pgood kept", term_pgood, 1'b1);
        main_ov = 0; tick(4);
        main_supply_ok = 0; tick(6); main_supply_ok = 1; tick(6);
        check("R11 main cleared by supply toggle", main_lo_force, 1'b0);

        // R8: simultaneous overvoltage and undervoltage
        term_ov = 1; term_uv = 1; tick(8);
        check("R8 overvoltage wins", term_lo_force, 1'b1);
        check("R8 no tri-state", term_hiz, 1'b0);
        check("R9 main untouched", main_pgood, 1'b1);
        term_ov = 0; term_uv = 0; tick(8);
        term_ref_ok = 0; tick(6); term_ref_ok = 1; tick(8);
        check("R12 term cleared after dual fault", term_lo_force, 1'b0);

        tick(4);
        finish_run();
    end

endmodule